// File: doc/BRIEF.md
# Token-Ring Polled Flag Bus Scanner

The scanner places a device's per-queue almost-full flags on a narrow shared status bus, one group of queues (a sector) at a time. While the device owns the bus it moves to the next sector on every rising clock edge. It always steps through every sector, however many queues are actually in use. When it has shown its last sector it gives up the bus.

Several devices can share one bus. Ownership moves between them as a token that travels around a ring: each device's token output feeds the next device's token input, and the last device feeds the first. After master reset the device strapped as master takes the bus first. The other devices stay idle until the token reaches them. A sync output marks the cycle in which a device shows its own first sector, so a receiver can find its place in the rotation.

A device that does not own the bus deasserts its output enable and drives zeros. The board-level bus can therefore be built as a wired OR or as tri-state drivers. A lone device wires its token output back to its own token input so that it keeps scanning.

Top module: `flag_ring_scanner`

## Requirements
- R1: While rst_ni is low: bus_oe_o=0, sync_o=0, token_o=0, token_err_o=0 and bus_o=0.
- R2: With master_i=1, the device owns the bus from the first rising edge after rst_ni goes high. In that cycle it shows sector 0 (flags_i[7:0]) with sync_o=1.
- R3: With master_i=0, the device keeps bus_oe_o=0 after reset until it samples token_i=1.
- R4: While the device owns the bus, it shows sector k as bus_o = flags_i[8k+7:8k]. The sector number goes up by one on each rising edge, from 0 to NUM_SECTORS-1.
- R5: sync_o=1 exactly in owned cycles that show sector 0. It is 0 in every other cycle.
- R6: token_o is a single-cycle pulse, high only in the owned cycle that shows the last sector. On the next edge the device releases the bus unless token_i is high at that edge.
- R7: When a non-owning device samples token_i=1, it shows sector 0 on the very next cycle, with no idle cycle between owners.
- R8: When bus_oe_o=0, bus_o=0.
- R9: token_i=1 sampled while the device owns the bus and is not in its last sector has no effect on the sector sequence. token_err_o goes high for the following cycle.
- R10: A master device with token_o wired to its own token_i scans sectors without a break. Its bus_oe_o stays at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous master reset |
| master_i | input | 1 | Strap; 1 = takes the bus first after reset |
| flags_i | input | NUM_SECTORS*SECTOR_W | Per-queue almost-full flags, queue q at bit q |
| token_i | input | 1 | Token pulse from previous device in ring |
| bus_o | output | SECTOR_W | Shared status bus data, zero when not owning |
| bus_oe_o | output | 1 | High while device owns the bus |
| sync_o | output | 1 | High while own sector 0 is shown |
| token_o | output | 1 | Token pulse to next device in ring |
| token_err_o | output | 1 | Pulse after a token arrives mid-ownership |

## Verification
The bench builds a ring of three scanners and checks the handoff cycle at every owner change. A design that adds an idle gap, or lets two devices overlap, breaks the one-hot enable pattern and the shared bus value. It injects stray tokens into a device that is showing its first sector. A design that obeys them restarts at sector 0 or drops the bus, and one that ignores them silently never raises the error pulse. A lone master on a self-loop must show no dead cycle at the wrap. A lone non-master on a self-loop must never start, which catches a design that acts on the strap or a reset artifact instead of a real token.

// File: rtl/flag_scan_pkg.sv
package flag_scan_pkg;
  typedef enum logic {
    SCAN_IDLE = 1'b0,
    SCAN_OWN  = 1'b1
  } scan_state_e;
endpackage

// File: rtl/fscan_owner_ctrl.sv
module fscan_owner_ctrl
  import flag_scan_pkg::*;
#(
  parameter int NUM_SECTORS = 2,
  localparam int SEC_W = (NUM_SECTORS > 1) ? $clog2(NUM_SECTORS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             master_i,
  input  logic             token_i,
  output logic             own_o,
  output logic [SEC_W-1:0] sec_o,
  output logic             last_o
);
  localparam logic [SEC_W-1:0] SEC_LAST = SEC_W'(NUM_SECTORS - 1);

  scan_state_e      state_q, state_d;
  logic [SEC_W-1:0] sec_q, sec_d;
  logic             fresh_q;
  logic             own, last, claim;

  assign own   = (state_q == SCAN_OWN);
  assign last  = own && (sec_q == SEC_LAST);
  // first edge after reset for master, or token when free / finishing
  assign claim = (fresh_q && master_i) || (token_i && (!own || last));

  always_comb begin
    state_d = state_q;
    sec_d   = sec_q;
    if (claim) begin
      state_d = SCAN_OWN;
      sec_d   = '0;
    end else if (own) begin
      if (last) begin
        state_d = SCAN_IDLE;
        sec_d   = '0;
      end else begin
        sec_d = sec_q + SEC_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SCAN_IDLE;
      sec_q   <= '0;
      fresh_q <= 1'b1;
    end else begin
      state_q <= state_d;
      sec_q   <= sec_d;
      fresh_q <= 1'b0;
    end
  end

  assign own_o  = own;
  assign sec_o  = sec_q;
  assign last_o = last;

  assert_master_claim_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fresh_q && master_i) |=> (own_o && sec_o == '0));

  assert_idle_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!own_o && !token_i && !(fresh_q && master_i)) |=> !own_o);

  assert_sector_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (own_o && !last_o) |=> (own_o && sec_o == $past(sec_o) + SEC_W'(1)));

  assert_release_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_o && !token_i) |=> !own_o);

  assert_last_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> !last_o);

  assert_token_claim_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (token_i && (!own_o || last_o)) |=> (own_o && sec_o == '0));
endmodule

// File: rtl/fscan_sector_mux.sv
module fscan_sector_mux #(
  parameter int NUM_SECTORS = 2,
  parameter int SECTOR_W    = 8,
  localparam int SEC_W  = (NUM_SECTORS > 1) ? $clog2(NUM_SECTORS) : 1,
  localparam int FLAG_W = NUM_SECTORS * SECTOR_W
) (
  input  logic [FLAG_W-1:0]   flags_i,
  input  logic [SEC_W-1:0]    sec_i,
  input  logic                own_i,
  output logic [SECTOR_W-1:0] bus_o
);
  logic [SECTOR_W-1:0] sector [NUM_SECTORS];

  for (genvar s = 0; s < NUM_SECTORS; s++) begin : g_sector
    assign sector[s] = flags_i[s*SECTOR_W +: SECTOR_W];
  end

  always_comb begin
    bus_o = '0;
    if (own_i) begin
      for (int s = 0; s < NUM_SECTORS; s++) begin
        if (sec_i == SEC_W'(s)) bus_o = sector[s];
      end
    end
  end
endmodule

// File: rtl/fscan_token_guard.sv
module fscan_token_guard (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic token_i,
  input  logic own_i,
  input  logic last_i,
  output logic err_o
);
  logic err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= token_i && own_i && !last_i;
  end

  assign err_o = err_q;
endmodule

// File: rtl/flag_ring_scanner.sv
module flag_ring_scanner #(
  parameter int NUM_SECTORS = 2,
  parameter int SECTOR_W    = 8,
  localparam int SEC_W  = (NUM_SECTORS > 1) ? $clog2(NUM_SECTORS) : 1,
  localparam int FLAG_W = NUM_SECTORS * SECTOR_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                master_i,
  input  logic [FLAG_W-1:0]   flags_i,
  input  logic                token_i,
  output logic [SECTOR_W-1:0] bus_o,
  output logic                bus_oe_o,
  output logic                sync_o,
  output logic                token_o,
  output logic                token_err_o
);
  logic             own, last;
  logic [SEC_W-1:0] sec;

  fscan_owner_ctrl #(.NUM_SECTORS(NUM_SECTORS)) i_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .master_i (master_i),
    .token_i  (token_i),
    .own_o    (own),
    .sec_o    (sec),
    .last_o   (last)
  );

  fscan_sector_mux #(.NUM_SECTORS(NUM_SECTORS), .SECTOR_W(SECTOR_W)) i_mux (
    .flags_i (flags_i),
    .sec_i   (sec),
    .own_i   (own),
    .bus_o   (bus_o)
  );

  fscan_token_guard i_guard (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .token_i (token_i),
    .own_i   (own),
    .last_i  (last),
    .err_o   (token_err_o)
  );

  assign bus_oe_o = own;
  assign sync_o   = own && (sec == '0);
  assign token_o  = last;

  assert_first_sync_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_oe_o) |-> sync_o);

  assert_stray_token_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (token_i && bus_oe_o && !token_o) |=> (token_err_o && bus_oe_o && !sync_o));
endmodule

// File: tb/test_flag_ring_scanner.sv
module test_flag_ring_scanner;
  localparam int CLK_P  = 10;
  localparam int NDEV   = 3;
  localparam int NSTEP  = 120;

  typedef struct packed {
    logic [2:0]  oe;
    logic [2:0]  sync;
    logic [2:0]  tok;
    logic [2:0]  err;
    logic [23:0] bus;
    logic        solo_oe;
    logic        solo_sync;
    logic [7:0]  solo_bus;
    logic        idle_oe;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] fl [NDEV];
  logic [15:0] solo_fl, idle_fl;
  logic [2:0]  inj = '0;
  logic [2:0]  tok_out, oe, sync, err;
  logic [7:0]  bus_d [NDEV];
  logic        solo_tok, solo_oe, solo_sync, solo_err;
  logic [7:0]  solo_bus;
  logic        idle_tok, idle_oe, idle_sync, idle_err;
  logic [7:0]  idle_bus;
  int          n_chk = 0;
  int          n_bad = 0;
  exp_t        q[$];

  always #(CLK_P/2) clk = ~clk;

  for (genvar k = 0; k < NDEV; k++) begin : g_dev
    flag_ring_scanner i_flag_ring_scanner (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .master_i    (k == 0),
      .flags_i     (fl[k]),
      .token_i     (tok_out[(k+NDEV-1)%NDEV] | inj[k]),
      .bus_o       (bus_d[k]),
      .bus_oe_o    (oe[k]),
      .sync_o      (sync[k]),
      .token_o     (tok_out[k]),
      .token_err_o (err[k])
    );
  end

  flag_ring_scanner i_flag_ring_scanner_solo (
    .clk_i(clk), .rst_ni(rst_n), .master_i(1'b1), .flags_i(solo_fl),
    .token_i(solo_tok), .bus_o(solo_bus), .bus_oe_o(solo_oe),
    .sync_o(solo_sync), .token_o(solo_tok), .token_err_o(solo_err)
  );

  flag_ring_scanner i_flag_ring_scanner_idle (
    .clk_i(clk), .rst_ni(rst_n), .master_i(1'b0), .flags_i(idle_fl),
    .token_i(idle_tok), .bus_o(idle_bus), .bus_oe_o(idle_oe),
    .sync_o(idle_sync), .token_o(idle_tok), .token_err_o(idle_err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // monitor: compare one expected item per cycle, after the edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check("R2/R3/R7 ring enables", {29'd0, oe}, {29'd0, e.oe});
      check("R5 ring sync", {29'd0, sync}, {29'd0, e.sync});
      check("R6 ring token_o", {29'd0, tok_out}, {29'd0, e.tok});
      check("R9 ring token_err", {29'd0, err}, {29'd0, e.err});
      check("R4/R8 ring buses", {8'd0, bus_d[2], bus_d[1], bus_d[0]}, {8'd0, e.bus});
      check("R10 solo scan", {22'd0, solo_oe, solo_sync, solo_bus},
            {22'd0, e.solo_oe, e.solo_sync, e.solo_bus});
      check("R3 idle non-master", {31'd0, idle_oe}, {31'd0, e.idle_oe});
    end
  end

  initial begin
    #(CLK_P * 5000);
    n_bad++;
    $display("FAIL watchdog R6 actual=hung expected=done");
    summary();
  end

  initial begin
    for (int k = 0; k < NDEV; k++) fl[k] = 16'h0;
    solo_fl = 16'h0;
    idle_fl = 16'h0;
    repeat (3) @(negedge clk);
    #1;
    for (int k = 0; k < NDEV; k++) fl[k] = 16'hffff;
    #1;
    // R1: reset state at every output
    check("R1 reset oe", {29'd0, oe}, 32'd0);
    check("R1 reset sync", {29'd0, sync}, 32'd0);
    check("R1 reset token", {29'd0, tok_out}, 32'd0);
    check("R1 reset err", {29'd0, err}, 32'd0);
    check("R1 reset bus", {8'd0, bus_d[2], bus_d[1], bus_d[0]}, 32'd0);
    for (int n = 0; n < NSTEP; n++) begin
      exp_t e;
      int owner, sec;
      if (n == 0) rst_n = 1'b1;
      for (int k = 0; k < NDEV; k++) fl[k] = 16'($urandom);
      solo_fl = 16'($urandom);
      idle_fl = 16'($urandom);
      // stray tokens while owner is in sector 0 of the previous cycle
      inj = '0;
      if (n == 7)  inj[0] = 1'b1;
      if (n == 9)  inj[1] = 1'b1;
      if (n == 17) inj[2] = 1'b1;
      owner = (n / 2) % NDEV;
      sec   = n % 2;
      e = '0;
      e.oe[owner]   = 1'b1;
      e.sync[owner] = (sec == 0);
      e.tok[owner]  = (sec == 1);
      e.err         = inj;
      e.bus[owner*8 +: 8] = fl[owner][sec*8 +: 8];
      e.solo_oe   = 1'b1;
      e.solo_sync = (sec == 0);
      e.solo_bus  = solo_fl[sec*8 +: 8];
      e.idle_oe   = 1'b0;
      q.push_back(e);
      @(negedge clk);
      #1;
    end
    inj = '0;
    @(negedge clk);
    #1;
    summary();
  end
endmodule